// File: doc/BRIEF.md
# Power-Switch Fault Status and Alert Reporter

This block records fault events from a power-switch controller as sticky status bits spread over six status registers. It drives three output pins: an active-low host alert, a power-good output and a fault output. Each pin responds only when its function select picks that function, and the alert and fault pins also honour their mask registers.

A short-circuit trip sets one pattern of status bits when the controller is in latched mode. It sets a wider pattern when the controller is in retry mode, where the trip ends in thermal shutdown. A separate event input records that an input line transient was detected and suppressed.

Software reads the registers through a combinational read port. It clears them through a write-one-to-clear port. The pins are registered, so they change one clock after the status bits that feed them.

Top module: `fault_status_reporter`

## Requirements
- R1: After reset every status register reads 0x00, `alert_n` is high and `flt_out` is low.
- R2: A short-circuit event with `retry_mode`=0 sets these bits on the next clock edge: switch-off (bit 2) and unknown (bit 0) in the status byte at address 0, giving 0x05; output (bit 3), power-good-bad (bit 1) and unknown (bit 0) in the word upper byte at address 1, giving 0x0B; output undervoltage warning (bit 0) at address 2, giving 0x01; power-good-bad (bit 0) and short-circuit fault (bit 1) at address 5, giving 0x03.
- R3: A short-circuit event with `retry_mode`=1 sets these bits: address 0 bits 2, 1 (temperature) and 0, giving 0x07; address 1 bits 3, 2 (manufacturer), 1 and 0, giving 0x0F; address 2 bit 0; overtemperature fault bit 0 at address 3; SOA fault bit 0 at address 4; power-good-bad bit 0 at address 5. The short-circuit fault bit (address 5 bit 1) is not set.
- R4: A line-transient event sets bit 2 of address 5.
- R5: Status bits stay set until a write with `wr_en` at their address carries a 1 in their position. Bits written 0 are kept.
- R6: When a write clears a bit in the same cycle as an event sets it, the bit ends up set.
- R7: `alert_n` goes low one clock after a contributing status bit is set, provided that bit's category is unmasked and `pin_a_sel`=2. The categories and their `alert_mask` bits (1 = masked) are: power-good-bad in the word (bit 0), output in the word (bit 1), manufacturer in the word (bit 2) and temperature in the byte (bit 3).
- R8: When `pin_p_sel`=1, `pg_out` is the inverse of the word power-good-bad bit, delayed by one clock.
- R9: `flt_out` goes high one clock after an unmasked fault bit is set, provided `pin_f_sel`=1. The fault bits and their `fault_mask` bits (1 = masked) are: short-circuit fault (bit 0), SOA fault (bit 1) and overtemperature fault (bit 2).
- R10: A pin whose select does not match its function is held inactive: `alert_n` high, `pg_out` low, `flt_out` low.
- R11: Reads of addresses 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_short | input | 1 | Short-circuit trip event pulse |
| retry_mode | input | 1 | 0 = latched response, 1 = retry response ending in thermal shutdown |
| ev_line_tran | input | 1 | Suppressed line-transient event pulse |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_addr | input | 3 | Register address of the clear |
| wr_data | input | 8 | Bits to clear |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| alert_mask | input | 4 | Alert category masks, 1 = masked |
| fault_mask | input | 3 | Fault pin masks, 1 = masked |
| pin_a_sel | input | 2 | Alert pin function select (2 = alert) |
| pin_p_sel | input | 2 | Power-good pin function select (1 = power good) |
| pin_f_sel | input | 2 | Fault pin function select (1 = fault) |
| alert_n | output | 1 | Host alert, active low |
| pg_out | output | 1 | Power-good output |
| flt_out | output | 1 | Fault output |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a new short-circuit event on the same register. The bench gets there by raising `ev_short` and a write of 0xFF to address 5 on the same falling edge, so both are sampled at one rising edge. A second hard case is the alert staying quiet in latched mode while it fires in retry mode under one and the same mask. The bench brings this about by masking only the latched-mode categories, then raising the retry-mode event without changing the mask.

// File: rtl/fault_status_reporter.sv
module fault_status_reporter #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter logic [1:0] FN_ALERT = 2'd2,
  parameter logic [1:0] FN_PG    = 2'd1,
  parameter logic [1:0] FN_FLT   = 2'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_short,
  input  logic          retry_mode,
  input  logic          ev_line_tran,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [3:0]    alert_mask,
  input  logic [2:0]    fault_mask,
  input  logic [1:0]    pin_a_sel,
  input  logic [1:0]    pin_p_sel,
  input  logic [1:0]    pin_f_sel,
  output logic          alert_n,
  output logic          pg_out,
  output logic          flt_out
);
  localparam int NREG = 6;

  logic [DW-1:0] sts [NREG];
  logic [DW-1:0] set_v [NREG];
  logic [DW-1:0] sts_byte, sts_word, sts_out, sts_temp, sts_mfr1, sts_mfr2;

  wire sc_lat = ev_short & ~retry_mode;
  wire sc_rty = ev_short &  retry_mode;

  always_comb begin
    for (int i = 0; i < NREG; i++) set_v[i] = '0;
    set_v[0][0] = ev_short;
    set_v[0][1] = sc_rty;
    set_v[0][2] = ev_short;
    set_v[1][0] = ev_short;
    set_v[1][1] = ev_short;
    set_v[1][2] = sc_rty;
    set_v[1][3] = ev_short;
    set_v[2][0] = ev_short;
    set_v[3][0] = sc_rty;
    set_v[4][0] = sc_rty;
    set_v[5][0] = ev_short;
    set_v[5][1] = sc_lat;
    set_v[5][2] = ev_line_tran;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    wire [DW-1:0] clr = (wr_en && wr_addr == AW'(g)) ? wr_data : '0;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sts[g] <= '0;
      else        sts[g] <= (sts[g] & ~clr) | set_v[g];
  end

  assign sts_byte = sts[0];
  assign sts_word = sts[1];
  assign sts_out  = sts[2];
  assign sts_temp = sts[3];
  assign sts_mfr1 = sts[4];
  assign sts_mfr2 = sts[5];

  assign rd_data = (int'(rd_addr) < NREG) ? sts[rd_addr] : '0;

  wire [3:0] alert_src = {sts_byte[1], sts_word[2], sts_word[3], sts_word[1]};
  wire [2:0] fault_src = {sts_temp[0], sts_mfr1[0], sts_mfr2[1]};
  wire alert_d = (pin_a_sel == FN_ALERT) && |(alert_src & ~alert_mask);
  wire fault_d = (pin_f_sel == FN_FLT) && |(fault_src & ~fault_mask);
  wire pg_d    = (pin_p_sel == FN_PG) && !sts_word[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alert_n <= 1'b1;
      flt_out <= 1'b0;
      pg_out  <= 1'b0;
    end else begin
      alert_n <= !alert_d;
      flt_out <= fault_d;
      pg_out  <= pg_d;
    end
endmodule

// File: rtl/fault_status_checker.sv
module fault_status_checker #(
  parameter int DW = 8,
  parameter logic [1:0] FN_ALERT = 2'd2,
  parameter logic [1:0] FN_PG    = 2'd1,
  parameter logic [1:0] FN_FLT   = 2'd1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_short,
  input logic          retry_mode,
  input logic          ev_line_tran,
  input logic          wr_en,
  input logic [1:0]    pin_a_sel,
  input logic [1:0]    pin_p_sel,
  input logic [1:0]    pin_f_sel,
  input logic          alert_n,
  input logic          pg_out,
  input logic          flt_out,
  input logic [DW-1:0] sts_byte,
  input logic [DW-1:0] sts_temp,
  input logic [DW-1:0] sts_mfr1,
  input logic [DW-1:0] sts_mfr2
);
  AST_LATCHED_SC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_short && !retry_mode |=> sts_mfr2[1] && sts_mfr2[0]); // R2
  AST_RETRY_THERMAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_short && retry_mode |=> sts_temp[0] && sts_mfr1[0] && sts_byte[1]); // R3
  AST_LINE_TRAN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_line_tran |=> sts_mfr2[2]); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (sts_byte & $past(sts_byte)) == $past(sts_byte)); // R5
  AST_ALERT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pin_a_sel != FN_ALERT |=> alert_n); // R10
  AST_PG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pin_p_sel != FN_PG |=> !pg_out); // R10
  AST_FLT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pin_f_sel != FN_FLT |=> !flt_out); // R10
endmodule

bind fault_status_reporter fault_status_checker #(
  .DW(DW), .FN_ALERT(FN_ALERT), .FN_PG(FN_PG), .FN_FLT(FN_FLT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_short(ev_short), .retry_mode(retry_mode),
  .ev_line_tran(ev_line_tran), .wr_en(wr_en), .pin_a_sel(pin_a_sel),
  .pin_p_sel(pin_p_sel), .pin_f_sel(pin_f_sel), .alert_n(alert_n),
  .pg_out(pg_out), .flt_out(flt_out), .sts_byte(sts_byte),
  .sts_temp(sts_temp), .sts_mfr1(sts_mfr1), .sts_mfr2(sts_mfr2)
);

// File: tb/tb_fault_status_reporter.sv
module tb_fault_status_reporter;
  logic clk = 0, rst_n = 0;
  logic ev_short = 0, retry_mode = 0, ev_line_tran = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [3:0] alert_mask = 0;
  logic [2:0] fault_mask = 0;
  logic [1:0] pin_a_sel = 2, pin_p_sel = 1, pin_f_sel = 1;
  logic alert_n, pg_out, flt_out;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  fault_status_reporter dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic chk_reg(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic pulse_sc(logic mode);
    @(negedge clk); ev_short = 1; retry_mode = mode;
    @(negedge clk); ev_short = 0;
  endtask

  task automatic clr(logic [2:0] a, logic [7:0] m);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = m;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clr_all();
    for (int i = 0; i < 6; i++) clr(3'(i), 8'hFF);
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) chk_reg("R1 status reg", 3'(i), 8'h00);
    chk("R1 alert_n", {7'b0, alert_n}, 8'h01);
    chk("R1 flt_out", {7'b0, flt_out}, 8'h00);
    chk("R8 pg_out idle", {7'b0, pg_out}, 8'h01);
  endtask

  task automatic t_latched();
    pulse_sc(0);
    chk_reg("R2 byte", 0, 8'h05); chk_reg("R2 word", 1, 8'h0B);
    chk_reg("R2 out", 2, 8'h01); chk_reg("R2 temp", 3, 8'h00);
    chk_reg("R2 mfr1", 4, 8'h00); chk_reg("R2 mfr2", 5, 8'h03);
    @(negedge clk);
    chk("R7 alert low", {7'b0, alert_n}, 8'h00);
    chk("R9 flt high sc", {7'b0, flt_out}, 8'h01);
    chk("R8 pg low", {7'b0, pg_out}, 8'h00);
    clr_all();
    chk("R5 alert recovers", {7'b0, alert_n}, 8'h01);
    chk("R8 pg recovers", {7'b0, pg_out}, 8'h01);
    chk_reg("R5 mfr2 cleared", 5, 8'h00);
  endtask

  task automatic t_retry();
    pulse_sc(1);
    chk_reg("R3 byte", 0, 8'h07); chk_reg("R3 word", 1, 8'h0F);
    chk_reg("R3 out", 2, 8'h01); chk_reg("R3 temp", 3, 8'h01);
    chk_reg("R3 mfr1", 4, 8'h01); chk_reg("R3 mfr2 no sc", 5, 8'h01);
    @(negedge clk);
    chk("R9 flt high retry", {7'b0, flt_out}, 8'h01);
    clr_all();
  endtask

  task automatic t_alert_mask();
    alert_mask = 4'b0011;
    pulse_sc(0); @(negedge clk);
    chk("R7 latched masked", {7'b0, alert_n}, 8'h01);
    pulse_sc(1); @(negedge clk);
    chk("R7 retry unmasked temp/mfr", {7'b0, alert_n}, 8'h00);
    alert_mask = 4'b0111; @(negedge clk); @(negedge clk);
    chk("R7 temp alone", {7'b0, alert_n}, 8'h00);
    alert_mask = 4'b1111; @(negedge clk); @(negedge clk);
    chk("R7 all masked", {7'b0, alert_n}, 8'h01);
    alert_mask = 0; clr_all();
  endtask

  task automatic t_fault_mask();
    fault_mask = 3'b001;
    pulse_sc(0); @(negedge clk);
    chk("R9 sc masked", {7'b0, flt_out}, 8'h00);
    clr_all();
    fault_mask = 3'b010;
    pulse_sc(1); @(negedge clk);
    chk("R9 ot unmasked", {7'b0, flt_out}, 8'h01);
    fault_mask = 3'b110; @(negedge clk); @(negedge clk);
    chk("R9 soa+ot masked", {7'b0, flt_out}, 8'h00);
    fault_mask = 0; clr_all();
  endtask

  task automatic t_sel();
    pin_a_sel = 1; pin_p_sel = 0; pin_f_sel = 3;
    @(negedge clk); @(negedge clk);
    chk("R10 pg idle unselected", {7'b0, pg_out}, 8'h00);
    pulse_sc(1); @(negedge clk);
    chk("R10 alert unselected", {7'b0, alert_n}, 8'h01);
    chk("R10 flt unselected", {7'b0, flt_out}, 8'h00);
    pin_a_sel = 2; pin_p_sel = 1; pin_f_sel = 1;
    clr_all();
  endtask

  task automatic t_partial();
    pulse_sc(0);
    clr(0, 8'h04);
    chk_reg("R5 partial clear", 0, 8'h01);
    clr_all();
  endtask

  task automatic t_collide();
    @(negedge clk); ev_short = 1; retry_mode = 0; wr_en = 1; wr_addr = 5; wr_data = 8'hFF;
    @(negedge clk); ev_short = 0; wr_en = 0;
    chk_reg("R6 set beats clear", 5, 8'h03);
    clr_all();
  endtask

  task automatic t_tran();
    @(negedge clk); ev_line_tran = 1;
    @(negedge clk); ev_line_tran = 0;
    chk_reg("R4 line transient", 5, 8'h04);
    chk_reg("R4 byte untouched", 0, 8'h00);
    clr_all();
  endtask

  task automatic t_unmapped();
    pulse_sc(1);
    chk_reg("R11 addr6", 6, 8'h00);
    chk_reg("R11 addr7", 7, 8'h00);
    clr_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    t_reset(); t_latched(); t_retry(); t_alert_mask(); t_fault_mask();
    t_sel(); t_partial(); t_collide(); t_tran(); t_unmapped();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #400000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule